// File: doc/BRIEF.md
# Voice Activity Duty-Cycle Integrator

This block turns a fast, jittery voice-activity flag into a slow, steady one. On every sample tick it records the gated fast flag into a sliding history of 182 samples, which covers about 728 ms at a 4 ms tick. It keeps a running count of the high samples in that history. A slow flag is set when the count rises above a high threshold and cleared when it falls below a low one. The wide gap between the two thresholds stops the slow flag from toggling during normal speech pauses.

Both outputs are gated by a signal-level qualifier and by an enable input. Dropping the enable wipes the history and the slow state. After the enable returns, the outputs stay at 0 for a short warm-up of a few ticks, and recording begins once the warm-up ends. Typical use is in billing or line-monitoring logic, which reads the slow flag to decide that a conversation has started.

Top module: `voice_duty_integrator`

## Requirements
- R1: The history holds the last 182 recorded samples. A sample (the value on voice_fast_o) is recorded only on a cycle with tick_i high, after warm-up. Cycles without a tick leave the count unchanged.
- R2: voice_slow_o's internal state becomes 1 one clock after the count of high samples exceeds 92. A count of exactly 92 does not set it.
- R3: The slow state becomes 0 one clock after the count drops below 19. A count of exactly 19 does not clear it.
- R4: For counts from 19 to 92 inclusive, the slow state keeps its previous value.
- R5: While level_ok_i is low, voice_fast_o and voice_slow_o read 0. The slow state is kept, so the slow output shows it again when level_ok_i returns high.
- R6: While enable_i is low, both outputs read 0. The history, the count and the slow state are cleared.
- R7: After enable_i rises, both outputs stay 0 until 4 ticks have passed. Recording starts with the 5th tick.
- R8: After reset, both outputs are 0 and the history is all zeros.
- R9: When enabled, warmed up and level-qualified, voice_fast_o follows voice_fast_i combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample strobe, one cycle wide, nominally every 4 ms |
| enable_i | input | 1 | Block enable; low clears all state |
| level_ok_i | input | 1 | Input level above detection threshold |
| voice_fast_i | input | 1 | Raw fast voice-activity flag |
| voice_fast_o | output | 1 | Gated fast voice flag |
| voice_slow_o | output | 1 | Integrated slow voice flag |

## Verification
On every cycle, the assertions check four things. The count stays within the window length and moves only on a tick. The slow state follows the set, clear and hold rules one clock after the count. Disable clears the count and the ready state. The bench scenarios cover what the assertions cannot see: the exact boundary counts 92/93 and 19/18 reached through the window's own expiry of old samples, survival of the slow state through a level dropout, and the warm-up and history wipe after a disable.

// File: rtl/vdi_pkg.sv
package vdi_pkg;
  typedef enum logic [1:0] {
    DEC_HOLD = 2'd0,
    DEC_SET  = 2'd1,
    DEC_CLR  = 2'd2
  } vdi_dec_e;
endpackage

// File: rtl/vdi_history.sv
module vdi_history #(
  parameter int unsigned WIN_LEN = 182,
  localparam int unsigned CNT_W  = $clog2(WIN_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             sample_i,
  input  logic             bit_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [WIN_LEN-1:0] hist_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               oldest;

  assign oldest = hist_q[WIN_LEN-1];
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      cnt_q  <= '0;
    end else if (clear_i) begin
      hist_q <= '0;
      cnt_q  <= '0;
    end else if (sample_i) begin
      hist_q <= {hist_q[WIN_LEN-2:0], bit_i};
      // add incoming, drop expiring
      cnt_q  <= cnt_q + CNT_W'(bit_i) - CNT_W'(oldest);
    end
  end

  assert_cnt_in_window_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(WIN_LEN));
  assert_cnt_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sample_i && !clear_i) |=> $stable(cnt_q));
  assert_clear_empties_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/vdi_hysteresis.sv
module vdi_hysteresis
  import vdi_pkg::*;
#(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned SET_CNT = 92,
  parameter int unsigned CLR_CNT = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             slow_o
);
  vdi_dec_e dec;
  logic     slow_q;

  always_comb begin
    if (cnt_i > CNT_W'(SET_CNT))      dec = DEC_SET;
    else if (cnt_i < CNT_W'(CLR_CNT)) dec = DEC_CLR;
    else                              dec = DEC_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        slow_q <= 1'b0;
    else if (clear_i)   slow_q <= 1'b0;
    else begin
      unique case (dec)
        DEC_SET:  slow_q <= 1'b1;
        DEC_CLR:  slow_q <= 1'b0;
        default:  slow_q <= slow_q;
      endcase
    end
  end

  assign slow_o = slow_q;

  assert_set_above_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && cnt_i > CNT_W'(SET_CNT)) |=> slow_q);
  assert_clr_below_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i < CNT_W'(CLR_CNT)) |=> !slow_q);
  assert_hold_between_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && cnt_i >= CNT_W'(CLR_CNT) && cnt_i <= CNT_W'(SET_CNT))
      |=> (slow_q == $past(slow_q)));
endmodule

// File: rtl/vdi_warmup.sv
module vdi_warmup #(
  parameter int unsigned INIT_TICKS = 4,
  localparam int unsigned W_W       = $clog2(INIT_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic tick_i,
  output logic ready_o
);
  logic [W_W-1:0] wcnt_q;
  logic           ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q  <= '0;
      ready_q <= 1'b0;
    end else if (!enable_i) begin
      wcnt_q  <= '0;
      ready_q <= 1'b0;
    end else if (tick_i && !ready_q) begin
      wcnt_q <= wcnt_q + 1'b1;
      if (wcnt_q == W_W'(INIT_TICKS - 1)) ready_q <= 1'b1;
    end
  end

  assign ready_o = ready_q;

  assert_ready_after_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_q) |-> $past(tick_i));
  assert_disable_unready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !ready_q);
endmodule

// File: rtl/voice_duty_integrator.sv
module voice_duty_integrator #(
  parameter int unsigned WIN_LEN    = 182,
  parameter int unsigned SET_CNT    = 92,
  parameter int unsigned CLR_CNT    = 19,
  parameter int unsigned INIT_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic enable_i,
  input  logic level_ok_i,
  input  logic voice_fast_i,
  output logic voice_fast_o,
  output logic voice_slow_o
);
  localparam int unsigned CNT_W = $clog2(WIN_LEN + 1);

  logic             ready;
  logic             valid;
  logic             sample;
  logic [CNT_W-1:0] cnt;
  logic             slow_state;

  vdi_warmup #(.INIT_TICKS(INIT_TICKS)) u_warmup (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .tick_i   (tick_i),
    .ready_o  (ready)
  );

  assign valid        = enable_i & ready & level_ok_i;
  assign voice_fast_o = voice_fast_i & valid;
  assign sample       = tick_i & enable_i & ready;

  vdi_history #(.WIN_LEN(WIN_LEN)) u_history (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (!enable_i),
    .sample_i (sample),
    .bit_i    (voice_fast_o),
    .cnt_o    (cnt)
  );

  vdi_hysteresis #(
    .CNT_W   (CNT_W),
    .SET_CNT (SET_CNT),
    .CLR_CNT (CLR_CNT)
  ) u_hyst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (!enable_i),
    .cnt_i   (cnt),
    .slow_o  (slow_state)
  );

  assign voice_slow_o = slow_state & valid;

  assert_warmup_mutes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready |-> (!voice_slow_o && !voice_fast_o));
  assert_level_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !level_ok_i |-> (!voice_slow_o && !voice_fast_o));
endmodule

// File: tb/voice_duty_integrator_tb.sv
module voice_duty_integrator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSEG = 10;
  // {ticks[8:0], fast, lvl, exp_slow}
  localparam logic [11:0] SEGS [NSEG] = '{
    {9'd92, 1'b1, 1'b1, 1'b0},  // R2 count 92, no set
    {9'd1,  1'b1, 1'b1, 1'b1},  // R2 count 93, set
    {9'd89, 1'b0, 1'b1, 1'b1},  // R4 window full, count 93
    {9'd74, 1'b0, 1'b1, 1'b1},  // R4 count 19, hold
    {9'd1,  1'b0, 1'b1, 1'b0},  // R3 count 18, clear
    {9'd40, 1'b1, 1'b1, 1'b0},  // R4 count 40, hold low
    {9'd10, 1'b1, 1'b0, 1'b0},  // R5 gated, zeros recorded
    {9'd53, 1'b1, 1'b1, 1'b1},  // R2 count 93 again
    {9'd5,  1'b1, 1'b0, 1'b0},  // R5 state kept but muted
    {9'd1,  1'b1, 1'b1, 1'b1}   // R5 state visible again
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, en = 1'b0, lvl = 1'b0, fast = 1'b0;
  logic fast_o, slow_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  voice_duty_integrator dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .enable_i(en),
    .level_ok_i(lvl), .voice_fast_i(fast),
    .voice_fast_o(fast_o), .voice_slow_o(slow_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic run_ticks(input int n, input logic f, input logic l);
    for (int i = 0; i < n; i++) begin
      fast = f; lvl = l; tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    fast = 1'b1; lvl = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 reset fast", fast_o, 1'b0);
    check("R8 reset slow", slow_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 disabled fast", fast_o, 1'b0);
    en = 1'b1;
    @(negedge clk);
    run_ticks(3, 1'b1, 1'b1);
    check("R7 warmup fast muted", fast_o, 1'b0);
    check("R7 warmup slow muted", slow_o, 1'b0);
    run_ticks(1, 1'b1, 1'b1);
    check("R9 fast follows after warmup", fast_o, 1'b1);
    fast = 1'b0; #1;
    check("R9 fast follows low", fast_o, 1'b0);
    lvl = 1'b0; fast = 1'b1; #1;
    check("R5 level gates fast", fast_o, 1'b0);
    @(negedge clk);

    // table walk; seg0 also shows R8 empty history
    for (int s = 0; s < NSEG; s++) begin
      run_ticks(int'(SEGS[s][11:3]), SEGS[s][2], SEGS[s][1]);
      check($sformatf("R2/R3/R4/R5 seg%0d slow", s), slow_o, SEGS[s][0]);
      check($sformatf("R9/R5 seg%0d fast", s), fast_o, SEGS[s][2] & SEGS[s][1]);
    end

    // R6: disable wipes everything
    en = 1'b0; #1;
    check("R6 disable mutes slow", slow_o, 1'b0);
    check("R6 disable mutes fast", fast_o, 1'b0);
    @(negedge clk); @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    check("R7 re-enable muted", slow_o, 1'b0);
    run_ticks(4, 1'b1, 1'b1);
    run_ticks(92, 1'b1, 1'b1);
    check("R6 history cleared, count 92", slow_o, 1'b0);
    // R1: cycles without tick record nothing
    fast = 1'b1;
    repeat (20) @(negedge clk);
    check("R1 no tick no change", slow_o, 1'b0);
    run_ticks(1, 1'b1, 1'b1);
    check("R1 single tick sets at 93", slow_o, 1'b1);
    finish_run();
  end
endmodule